// File: doc/BRIEF.md
# Collision and Jabber Supervisor

This block decides when a 10BASE-T medium attachment unit reports a collision to its station. A collision exists when the station is sending on the attachment interface and the twisted-pair receiver sees data at the same time. The block also keeps watch on how long a transmission lasts. A transmission that runs past a limit puts the block into jabber. Jabber blocks the path from the attachment interface to the line transmitter. Jabber ends only after outgoing activity has stayed quiet for a long recovery interval.

While a collision or jabber is in progress, the block drives a square-wave carrier toward the control-in pair. A heartbeat request from a separate generator also drives that carrier, but a heartbeat is never reported as a collision. The block has two active-low LED-capable outputs, one for collision and one for receive. The collision output is stretched after a collision ends. All timing counts pulses of an external millisecond tick, so the intervals stay correct at any clock rate.

Top module: `col_jab_sup`

## Requirements
- R1: In any cycle where `tx_act` and `rx_act` are both high, `col_n` is low from the next clock edge on.
- R2: After the last collision cycle, `col_n` stays low until `STRETCH_MS` pulses of `ms_tick` have arrived. It goes high on the edge after that last pulse, unless jabber or a new collision holds it low.
- R3: Once `tx_act` has stayed high through `JAB_MS` pulses of `ms_tick`, jabber is entered on the edge of the last pulse. Any cycle with `tx_act` low before then restarts the count. In jabber, `col_n` is low and `tx_data_out` is 0.
- R4: Jabber ends on the edge of the `UNJAB_MS`-th `ms_tick` pulse counted while `tx_act` is low throughout. Any cycle with `tx_act` high restarts that count from zero.
- R5: Outside jabber, `tx_data_out` equals `tx_data_in & tx_act` combinationally.
- R6: `ci_out` is a square wave only while collision, jabber or `sqe_act` was present in the previous cycle. The square wave holds each level for `CARRIER_HALF` clocks. Otherwise `ci_out` is 0.
- R7: `sqe_act` on its own never pulls `col_n` low.
- R8: `rcv_n` is low in every cycle where `col_n` is low. It is also low in the cycle after any cycle with `rx_act` high.
- R9: After reset, `col_n` and `rcv_n` are high, `ci_out` is 0, and the block is not in jabber.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, at least twice the carrier rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| tx_act | input | 1 | Outgoing data present on the attachment interface |
| tx_data_in | input | 1 | Outgoing data bit from the attachment interface |
| rx_act | input | 1 | Incoming twisted-pair data present |
| sqe_act | input | 1 | Heartbeat burst requested on the control-in pair |
| tx_data_out | output | 1 | Data bit forwarded to the twisted-pair transmitter |
| ci_out | output | 1 | Square-wave carrier for the control-in pair |
| col_n | output | 1 | Active-low collision indication, stretched |
| rcv_n | output | 1 | Active-low receive indication |

## Verification
The bench counts tick pulses right up to each limit, so a design whose jabber, unjab or stretch count is off by one changes state one pulse early or late and is caught. It places a short burst of transmit activity inside the recovery wait. A design that does not restart the unjab count would leave jabber too soon. It also breaks a long transmission just before the jabber limit, which catches a design that keeps counting across the gap. A heartbeat with no traffic must produce the carrier with `col_n` high, which exposes a design that ties the carrier enable to the collision output. Random traffic without ticks checks the transmit gating, the collision onset and the receive indication against a simple model of which collisions have been seen.

// File: rtl/col_jab_sup.sv
module col_jab_sup #(
  parameter int JAB_MS       = 50,
  parameter int UNJAB_MS     = 500,
  parameter int STRETCH_MS   = 40,
  parameter int CARRIER_HALF = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic tx_act,
  input  logic tx_data_in,
  input  logic rx_act,
  input  logic sqe_act,
  output logic tx_data_out,
  output logic ci_out,
  output logic col_n,
  output logic rcv_n
);
  localparam int JW = $clog2(JAB_MS + 1);
  localparam int UW = $clog2(UNJAB_MS + 1);
  localparam int SW = $clog2(STRETCH_MS + 1);
  localparam int DW = $clog2(CARRIER_HALF + 1);

  logic          jab_q;
  logic [JW-1:0] jcnt;
  logic [UW-1:0] ucnt;
  logic [SW-1:0] str;
  logic [DW-1:0] div;
  logic          sq, ci_en_q, col_q, rcv_q;

  wire coll    = tx_act & rx_act;
  wire col_nxt = coll | jab_q | (str != '0);

  assign tx_data_out = tx_data_in & tx_act & ~jab_q;
  assign ci_out      = ci_en_q & sq;
  assign col_n       = ~col_q;
  assign rcv_n       = ~rcv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      jab_q <= 1'b0;
      jcnt  <= '0;
      ucnt  <= '0;
    end else if (!jab_q) begin
      ucnt <= '0;
      if (!tx_act)
        jcnt <= '0;
      else if (ms_tick) begin
        if (jcnt == JW'(JAB_MS - 1)) begin
          jab_q <= 1'b1;
          jcnt  <= '0;
        end else
          jcnt <= jcnt + 1'b1;
      end
    end else begin
      if (tx_act)
        ucnt <= '0;
      else if (ms_tick) begin
        if (ucnt == UW'(UNJAB_MS - 1)) begin
          jab_q <= 1'b0;
          ucnt  <= '0;
        end else
          ucnt <= ucnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      str <= '0;
    else if (coll)
      str <= SW'(STRETCH_MS);
    else if (ms_tick && str != '0)
      str <= str - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div <= '0;
      sq  <= 1'b0;
    end else if (div == DW'(CARRIER_HALF - 1)) begin
      div <= '0;
      sq  <= ~sq;
    end else
      div <= div + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ci_en_q <= 1'b0;
      col_q   <= 1'b0;
      rcv_q   <= 1'b0;
    end else begin
      ci_en_q <= coll | jab_q | sqe_act;
      col_q   <= col_nxt;
      rcv_q   <= rx_act | col_nxt;
    end
  end
endmodule

module col_jab_sup_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_act,
  input logic rx_act,
  input logic tx_data_out,
  input logic ci_out,
  input logic col_n,
  input logic rcv_n,
  input logic jab,
  input logic ci_en
);
  // R1
  coll_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_act && rx_act) |=> !col_n);
  // R3
  jab_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jab |-> !tx_data_out);
  // R3
  jab_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jab |=> !col_n);
  // R6
  ci_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ci_en |-> !ci_out);
  // R8
  rcv_with_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !col_n |-> !rcv_n);
endmodule

bind col_jab_sup col_jab_sup_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_act(tx_act), .rx_act(rx_act),
  .tx_data_out(tx_data_out), .ci_out(ci_out), .col_n(col_n),
  .rcv_n(rcv_n), .jab(jab_q), .ci_en(ci_en_q)
);

// File: tb/test_col_jab_sup.sv
module test_col_jab_sup;
  localparam int JAB_MS = 50, UNJAB_MS = 500, STRETCH_MS = 40;

  logic clk = 1'b0, rst_n = 1'b0, ms_tick = 1'b0;
  logic tx_act = 1'b0, tx_data_in = 1'b0, rx_act = 1'b0, sqe_act = 1'b0;
  logic tx_data_out, ci_out, col_n, rcv_n;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  col_jab_sup i_col_jab_sup (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .tx_act(tx_act),
    .tx_data_in(tx_data_in), .rx_act(rx_act), .sqe_act(sqe_act),
    .tx_data_out(tx_data_out), .ci_out(ci_out), .col_n(col_n), .rcv_n(rcv_n)
  );

  function automatic logic exp_pass(logic t, logic d);
    return t & d;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    {tx_act, rx_act, sqe_act, tx_data_in, ms_tick} = '0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ms_tick = 1'b1;
      @(negedge clk) ms_tick = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic ci_highs(output int hi);
    hi = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (ci_out) hi++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int hi;
    logic seen;
    do_reset();
    // R9 reset state
    chk("R9 col_n", col_n, 1'b1);
    chk("R9 rcv_n", rcv_n, 1'b1);
    chk("R9 ci_out", ci_out, 1'b0);
    tx_act = 1; tx_data_in = 1; #1;
    chk("R9 no jab", tx_data_out, 1'b1);

    // R1 + R6 + R8 collision
    do_reset();
    tx_act = 1; rx_act = 1;
    @(negedge clk); @(negedge clk);
    chk("R1 col", col_n, 1'b0);
    chk("R8 rcv", rcv_n, 1'b0);
    ci_highs(hi);
    chk("R6 carrier duty", hi == 10, 1'b1);

    // R2 stretch
    rx_act = 0; tx_act = 0;
    repeat (2) @(negedge clk);
    chk("R6 quiet", ci_out, 1'b0);
    tick(STRETCH_MS - 1);
    chk("R2 held", col_n, 1'b0);
    tick(1);
    chk("R2 released", col_n, 1'b1);
    chk("R8 released", rcv_n, 1'b1);

    // R7 heartbeat only
    sqe_act = 1;
    repeat (2) @(negedge clk);
    ci_highs(hi);
    chk("R7 col high", col_n, 1'b1);
    chk("R6 sqe carrier", hi == 10, 1'b1);
    sqe_act = 0;

    // R3 count restart on gap
    do_reset();
    tx_act = 1; tx_data_in = 1;
    tick(JAB_MS - 1);
    @(negedge clk) tx_act = 0;
    @(negedge clk) tx_act = 1;
    tick(JAB_MS - 1);
    chk("R3 restart", col_n, 1'b1);
    #1 chk("R5 pass", tx_data_out, 1'b1);
    tick(1);
    chk("R3 jab col", col_n, 1'b0);
    #1 chk("R3 jab block", tx_data_out, 1'b0);
    ci_highs(hi);
    chk("R6 jab carrier", hi == 10, 1'b1);

    // R4 unjab with restart
    tx_act = 0;
    tick(UNJAB_MS - 1);
    chk("R4 still jab", col_n, 1'b0);
    tx_act = 1; #1;
    chk("R3 blocked in wait", tx_data_out, 1'b0);
    @(negedge clk); @(negedge clk) tx_act = 0;
    tick(UNJAB_MS - 1);
    chk("R4 restart", col_n, 1'b0);
    tick(1);
    chk("R4 unjab", col_n, 1'b1);
    tx_act = 1; #1;
    chk("R5 after unjab", tx_data_out, 1'b1);

    // random traffic, no ticks: R1 R5 R8
    void'($urandom(32'd2024));
    do_reset();
    seen = 0;
    for (int c = 0; c < 400; c++) begin
      logic t, r, d;
      t = $urandom % 2; r = ($urandom % 8) == 0; d = $urandom % 2;
      tx_act = t; rx_act = r; tx_data_in = d; #1;
      chk("R5 rand", tx_data_out, exp_pass(t, d));
      seen = seen | (t & r);
      @(negedge clk);
      chk("R1 rand", col_n, !seen);
      chk("R8 rand", rcv_n, !(r | seen));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule